// File: doc/BRIEF.md
# Masked Configuration Readback Verifier

This block watches a serial readback stream from a programmable device and compares it, bit by bit, against a golden image of the configuration that was downloaded. A mask stream arrives in step with the other two and gives one bit for every readback position. It tells the block whether that position holds a configuration bit, which must match the golden image, or a state bit (a flip-flop, memory or I/O value), which changes during normal operation and is not compared. Any difference on a configuration bit means the configuration memory has been disturbed, for example by a radiation upset.

A controller pulses the start input, then presents one position per valid strobe, with the readback bit, the expected bit and the mask bit together. An end marker closes the stream. The block reports a registered mismatch pulse for each failing compared bit, a saturating mismatch count, the index of the first failing bit, and a pass/fail verdict with a one-cycle result-valid pulse when the stream ends. Storing the golden and mask images, and working out which signal a state bit belongs to, are left to other logic.

Top module: `cfgv_top`

## Requirements
- R1: After reset, err_cnt_o, first_hit_o, first_idx_o, mism_o, done_o and pass_o are all 0, and strobes are ignored until the first start.
- R2: A strobe whose mask bit is 0 and whose readback bit differs from the expected bit raises mism_o for exactly the following cycle and increments err_cnt_o by one in that cycle.
- R3: A strobe whose mask bit is 1 never raises mism_o and never changes err_cnt_o, whatever the readback and expected bits are.
- R4: The bit index is 0 for the first strobe after start and advances by one on every accepted strobe, skipped positions included; first_idx_o reports this index.
- R5: On the first compared mismatch after start, first_hit_o goes to 1 and first_idx_o takes that strobe's index; later mismatches leave first_idx_o unchanged.
- R6: err_cnt_o stops at 2^CNT_W-1 and does not wrap.
- R7: The cycle after end_i is accepted, done_o is 1 for one cycle and pass_o is 1 exactly when err_cnt_o is 0; a strobe presented with end_i is counted first. pass_o then holds until the next start.
- R8: Strobes and end markers that arrive after the end of stream and before the next start change neither mism_o, err_cnt_o, first_idx_o nor pass_o.
- R9: start_i clears err_cnt_o, first_hit_o, first_idx_o and pass_o and sets the index to 0; a strobe in the same cycle as start_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new stream |
| bit_vld_i | input | 1 | Strobe: one stream position is present |
| rd_bit_i | input | 1 | Readback bit |
| gold_bit_i | input | 1 | Expected bit from the golden image |
| skip_bit_i | input | 1 | Mask bit: 0 compare, 1 state bit skipped |
| end_i | input | 1 | End-of-stream marker |
| mism_o | output | 1 | Pulse: the previous strobe was a compared mismatch |
| err_cnt_o | output | CNT_W | Saturating mismatch count |
| first_hit_o | output | 1 | A mismatch has been seen since start |
| first_idx_o | output | IDX_W | Index of the first mismatching bit |
| done_o | output | 1 | Result-valid pulse after end of stream |
| pass_o | output | 1 | Verdict: 1 when no compared bit differed |

## Verification
The hardest situations to reach are those where two events share one cycle: a failing bit that carries the end marker, which must already count in the verdict, and a strobe that coincides with start, which must be dropped. The bench drives both directly with its stimulus tasks, and reaches the saturation limit by building the bench with a 3-bit count and sending ten failing bits, so that counts past the limit are seen at the ports.

// File: rtl/cfgv_pkg.sv
package cfgv_pkg;
  typedef struct packed {
    logic rd;
    logic gold;
    logic skip;
  } cfgv_bit_t;
endpackage

// File: rtl/cfgv_cmp.sv
module cfgv_cmp
  import cfgv_pkg::*;
(
  input  logic      take_i,
  input  cfgv_bit_t smp_i,
  output logic      miss_o
);
  logic differ;
  always_comb begin
    differ = smp_i.rd ^ smp_i.gold;
    miss_o = take_i & ~smp_i.skip & differ;
  end
endmodule

// File: rtl/cfgv_cnt.sv
module cfgv_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (clr_i)                    cnt_nxt_o = '0;
    else if (inc_i && cnt_q != CMAX) cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q == CMAX) |=> cnt_q == CMAX);
  // R6
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/cfgv_ctl.sv
module cfgv_ctl #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_vld_i,
  input  logic             end_i,
  input  logic             miss_i,
  input  logic             cnt_zero_nxt_i,
  output logic             take_o,
  output logic             clr_o,
  output logic             first_hit_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic             done_o,
  output logic             pass_o
);
  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             done_q, done_d;
  logic             pass_q, pass_d;
  logic             fin;

  always_comb begin
    clr_o    = start_i;
    take_o   = bit_vld_i & active_q & ~start_i;
    fin      = end_i & active_q & ~start_i;
    active_d = active_q;
    idx_d    = idx_q;
    hit_d    = hit_q;
    fidx_d   = fidx_q;
    done_d   = 1'b0;
    pass_d   = pass_q;
    if (start_i) begin
      active_d = 1'b1;
      idx_d    = '0;
      hit_d    = 1'b0;
      fidx_d   = '0;
      pass_d   = 1'b0;
    end else begin
      if (take_o) begin
        idx_d = idx_q + 1'b1;
        if (miss_i && !hit_q) begin
          hit_d  = 1'b1;
          fidx_d = idx_q;
        end
      end
      if (fin) begin
        active_d = 1'b0;
        done_d   = 1'b1;
        pass_d   = cnt_zero_nxt_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      hit_q    <= 1'b0;
      fidx_q   <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      hit_q    <= hit_d;
      fidx_q   <= fidx_d;
      done_q   <= done_d;
      pass_q   <= pass_d;
    end
  end

  assign first_hit_o = hit_q;
  assign first_idx_o = fidx_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;

  // R5
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !start_i) |=> (hit_q && $stable(fidx_q)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!hit_q && !pass_q && idx_q == '0));
endmodule

// File: rtl/cfgv_top.sv
module cfgv_top
  import cfgv_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_vld_i,
  input  logic             rd_bit_i,
  input  logic             gold_bit_i,
  input  logic             skip_bit_i,
  input  logic             end_i,
  output logic             mism_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             first_hit_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic             done_o,
  output logic             pass_o
);
  cfgv_bit_t        smp;
  logic             take, clr, miss, mism_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign smp = '{rd: rd_bit_i, gold: gold_bit_i, skip: skip_bit_i};

  cfgv_cmp u_cmp (.take_i(take), .smp_i(smp), .miss_o(miss));

  cfgv_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(miss),
    .cnt_nxt_o(cnt_nxt), .cnt_o(err_cnt_o));

  cfgv_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .end_i(end_i), .miss_i(miss), .cnt_zero_nxt_i(cnt_nxt == '0),
    .take_o(take), .clr_o(clr), .first_hit_o(first_hit_o),
    .first_idx_o(first_idx_o), .done_o(done_o), .pass_o(pass_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mism_q <= 1'b0;
    else        mism_q <= miss;
  end
  assign mism_o = mism_q;

  // R2
  mism_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mism_o |-> (err_cnt_o != '0 && first_hit_o));
  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && skip_bit_i && !start_i) |=> (!mism_o && $stable(err_cnt_o)));
  // R7
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o == (err_cnt_o == '0)));
endmodule

// File: tb/tb_cfgv_top.sv
module tb_cfgv_top;
  localparam int IDX_W = 12;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, bit_vld_i = 1'b0, rd_bit_i = 1'b0;
  logic gold_bit_i = 1'b0, skip_bit_i = 1'b0, end_i = 1'b0;
  logic mism_o, first_hit_o, done_o, pass_o;
  logic [CNT_W-1:0] err_cnt_o;
  logic [IDX_W-1:0] first_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfgv_top #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .rd_bit_i(rd_bit_i), .gold_bit_i(gold_bit_i), .skip_bit_i(skip_bit_i),
    .end_i(end_i), .mism_o(mism_o), .err_cnt_o(err_cnt_o),
    .first_hit_o(first_hit_o), .first_idx_o(first_idx_o),
    .done_o(done_o), .pass_o(pass_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // drive one cycle at negedge, return 1 time unit after the posedge
  task automatic cyc(input bit st, input bit v, input bit rd, input bit gd,
                     input bit sk, input bit en);
    @(negedge clk);
    start_i = st; bit_vld_i = v; rd_bit_i = rd; gold_bit_i = gd;
    skip_bit_i = sk; end_i = en;
    @(posedge clk);
    #1;
    start_i = 1'b0; bit_vld_i = 1'b0; end_i = 1'b0;
  endtask

  task automatic do_start();
    cyc(1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chkv("R1 cnt", err_cnt_o, 0);
    chkv("R1 hit", first_hit_o, 0);
    chkv("R1 done", done_o, 0);
    chkv("R1 pass", pass_o, 0);
    cyc(0, 1, 1, 0, 0, 0);
    chkv("R1 strobe before start mism", mism_o, 0);
    chkv("R1 strobe before start cnt", err_cnt_o, 0);
  endtask

  task automatic t_clean();
    do_start();
    for (int i = 0; i < 6; i++) cyc(0, 1, i[0], i[0], 0, 0);
    cyc(0, 1, 1, 0, 1, 1);  // differing state bit carries the end marker
    chkv("R7 clean done", done_o, 1);
    chkv("R7 clean pass", pass_o, 1);
    chkv("R3 clean cnt", err_cnt_o, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chkv("R7 done one cycle", done_o, 0);
    chkv("R7 pass held", pass_o, 1);
  endtask

  task automatic t_mixed();
    do_start();
    cyc(0, 1, 1, 1, 0, 0);          // idx0 match
    cyc(0, 1, 0, 1, 1, 0);          // idx1 skipped difference
    chkv("R3 skip mism", mism_o, 0);
    chkv("R3 skip cnt", err_cnt_o, 0);
    cyc(0, 1, 0, 1, 0, 0);          // idx2 mismatch
    chkv("R2 mism pulse", mism_o, 1);
    chkv("R2 cnt one", err_cnt_o, 1);
    chkv("R4 first idx counts skipped", first_idx_o, 2);
    chkv("R5 hit set", first_hit_o, 1);
    cyc(0, 1, 1, 0, 0, 0);          // idx3 mismatch
    chkv("R2 cnt two", err_cnt_o, 2);
    chkv("R5 first idx kept", first_idx_o, 2);
    cyc(0, 0, 0, 0, 0, 1);
    chkv("R2 mism drops", mism_o, 0);
    chkv("R7 fail done", done_o, 1);
    chkv("R7 fail pass", pass_o, 0);
  endtask

  task automatic t_after_end();
    cyc(0, 1, 1, 0, 0, 0);
    chkv("R8 late mism", mism_o, 0);
    chkv("R8 late cnt", err_cnt_o, 2);
    cyc(0, 1, 0, 1, 0, 1);
    chkv("R8 late end done", done_o, 0);
    chkv("R8 late first idx", first_idx_o, 2);
    chkv("R8 late pass", pass_o, 0);
  endtask

  task automatic t_restart();
    cyc(1, 1, 1, 0, 0, 0);          // start with a failing strobe: dropped
    chkv("R9 cnt cleared", err_cnt_o, 0);
    chkv("R9 hit cleared", first_hit_o, 0);
    chkv("R9 pass cleared", pass_o, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chkv("R9 start strobe ignored", mism_o, 0);
    cyc(0, 1, 0, 1, 0, 1);          // idx0 mismatch carrying end
    chkv("R4 index zero after start", first_idx_o, 0);
    chkv("R7 end bit counted", err_cnt_o, 1);
    chkv("R7 end bit done", done_o, 1);
    chkv("R7 end bit fails", pass_o, 0);
  endtask

  task automatic t_sat();
    do_start();
    for (int i = 0; i < 10; i++) begin
      cyc(0, 1, 1, 0, 0, 0);
      chkv("R6 saturating count", err_cnt_o, (i + 1 > 7) ? 7 : i + 1);
    end
    cyc(0, 0, 0, 0, 0, 1);
    chkv("R6 held at max", err_cnt_o, 7);
    chkv("R7 sat fails", pass_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_clean();
    t_mixed();
    t_after_end();
    t_restart();
    t_sat();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule